// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block connects two 8-bit buses, called A and B, and can move data in either direction. Each direction has its own storage register and its own load strobe. A registered multiplexer picks what the far bus is driven with: either the live value of the near bus or the value held in the register. The two drive enables have opposite polarities. The B side is enabled by an active-high input, and the A side by an active-low one. With both enables inactive, the two buses are isolated.

Neither bus is a real tri-state net. Each bus has external data with a valid flag, and internal drive data with an enable. A resolver per bus forms the value the bus carries, and a keeper holds that value when nothing drives the bus. The registers always sample this resolved value. Driving B from live A and then loading the B-side register therefore puts the A data into both registers. With both live paths enabled, the two buses hold each other's last value after every external driver lets go.

All state is clocked by one system clock. A load takes place when a strobe is seen high on a clock where it was low on the clock before. A synchronous active-high reset clears all state to zero.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both internal drive enables are low and both stored registers and keepers read zero.
- R2: A register loads only on a clock where its strobe is high and was low on the previous clock. Holding the strobe high loads nothing further.
- R3: A register loads whatever the select and drive-enable inputs are set to.
- R4: One clock after a direction's select is sampled low, that direction's drive data equals the opposite bus value as resolved before that edge. When the select is sampled high, the drive data equals the stored register value instead.
- R5: `b_out_en` follows `drive_b_en` with one cycle of delay. `a_out_en` follows the inverse of `drive_a_n` with one cycle of delay. With `drive_b_en` low and `drive_a_n` high, neither bus is driven (isolation).
- R6: The A-to-B register samples resolved bus A and the B-to-A register samples resolved bus B. When B is driven live from A, loading the B-to-A register stores the A data.
- R7: With both live paths enabled, both buses keep their last value after the external drivers release.
- R8: A bus resolves to the external data when the external flag is set. Otherwise it resolves to the internal drive data when the internal enable is set. Otherwise it keeps the value it had on the previous clock.
- R9: A bus's clash flag is high exactly while its external flag and its internal drive enable are both high.
- R10: When both strobes rise on the same clock, each register captures its bus as resolved before that edge. This is allowed only while both selects are low.
- R11: When a select changes, the drive data moves directly from the old source to the new one on the next clock, with no other value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | External data on bus A |
| a_in_en | input | 1 | External driver active on bus A |
| b_in | input | 8 | External data on bus B |
| b_in_en | input | 1 | External driver active on bus B |
| load_ab | input | 1 | Load strobe for the A-to-B register (rising edge) |
| load_ba | input | 1 | Load strobe for the B-to-A register (rising edge) |
| pick_ab_store | input | 1 | 1: B is driven from the stored register, 0: from live A |
| pick_ba_store | input | 1 | 1: A is driven from the stored register, 0: from live B |
| drive_b_en | input | 1 | Active-high enable for the drivers on bus B |
| drive_a_n | input | 1 | Active-low enable for the drivers on bus A |
| a_bus | output | 8 | Resolved value of bus A |
| b_bus | output | 8 | Resolved value of bus B |
| a_out | output | 8 | Internal drive data toward bus A |
| a_out_en | output | 1 | Internal driver on bus A active |
| b_out | output | 8 | Internal drive data toward bus B |
| b_out_en | output | 1 | Internal driver on bus B active |
| a_clash | output | 1 | External and internal drivers both active on A |
| b_clash | output | 1 | External and internal drivers both active on B |

## Verification
The load-ordering assertion assumes the environment never raises both strobes on the same clock while either select is high. The random stimulus enforces this: it tracks each strobe's previous value and drops the B-to-A rise whenever both would rise together under a high select. Every other check assumes only that the inputs are stable around the clock edge. The bench meets that by driving inputs on the falling edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int NUM_DIR = 2;

    typedef enum logic [1:0] {
        SRC_KEEP     = 2'd0,
        SRC_INTERNAL = 2'd1,
        SRC_EXTERNAL = 2'd2
    } bus_src_e;

    typedef struct packed {
        logic load;
        logic pick_store;
        logic drive;
    } lane_ctl_t;

    function automatic bus_src_e pick_source(input logic ext_en, input logic int_en);
        if (ext_en)      return SRC_EXTERNAL;
        else if (int_en) return SRC_INTERNAL;
        else             return SRC_KEEP;
    endfunction

endpackage

// File: rtl/xcvr_rise.sv
module xcvr_rise (
    input  logic clk,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int DW            = 8,
    parameter bit OE_ACTIVE_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  xcvr_pkg::lane_ctl_t ctl,
    input  logic [DW-1:0]     src_bus,
    output logic [DW-1:0]     drv_data,
    output logic              drv_en
);
    logic          load_rise;
    logic [DW-1:0] store_q;
    logic          en_next;

    xcvr_rise u_rise (
        .clk    (clk),
        .strobe (ctl.load),
        .rise   (load_rise)
    );

    generate
        if (OE_ACTIVE_LOW) begin : g_en_low
            assign en_next = ~ctl.drive;
        end else begin : g_en_high
            assign en_next = ctl.drive;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q  <= '0;
            drv_data <= '0;
            drv_en   <= 1'b0;
        end else begin
            if (load_rise) store_q <= src_bus;
            drv_data <= ctl.pick_store ? store_q : src_bus;
            drv_en   <= en_next;
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.load) |=> store_q == $past(src_bus)); // R6
    AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$rose(ctl.load) |=> $stable(store_q)); // R2
    AST_STORED_PATH: assert property (@(posedge clk) disable iff (rst)
        ctl.pick_store |=> drv_data == $past(store_q)); // R4
    AST_LIVE_PATH: assert property (@(posedge clk) disable iff (rst)
        !ctl.pick_store |=> drv_data == $past(src_bus)); // R4
endmodule

// File: rtl/xcvr_resolve.sv
module xcvr_resolve #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ext_data,
    input  logic          ext_en,
    input  logic [DW-1:0] int_data,
    input  logic          int_en,
    output logic [DW-1:0] bus,
    output logic          clash
);
    import xcvr_pkg::*;

    bus_src_e      src;
    logic [DW-1:0] keep_q;

    assign src = pick_source(ext_en, int_en);

    always_comb begin
        unique case (src)
            SRC_EXTERNAL: bus = ext_data;
            SRC_INTERNAL: bus = int_data;
            default:      bus = keep_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) keep_q <= '0;
        else     keep_q <= bus;
    end

    assign clash = ext_en & int_en;

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
        ext_en |-> bus == ext_data); // R8
    AST_KEEPER_HOLDS: assert property (@(posedge clk) disable iff (rst || $past(rst))
        (!ext_en && !int_en) |-> bus == $past(bus)); // R8
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    input  logic          a_in_en,
    input  logic [DW-1:0] b_in,
    input  logic          b_in_en,
    input  logic          load_ab,
    input  logic          load_ba,
    input  logic          pick_ab_store,
    input  logic          pick_ba_store,
    input  logic          drive_b_en,
    input  logic          drive_a_n,
    output logic [DW-1:0] a_bus,
    output logic [DW-1:0] b_bus,
    output logic [DW-1:0] a_out,
    output logic          a_out_en,
    output logic [DW-1:0] b_out,
    output logic          b_out_en,
    output logic          a_clash,
    output logic          b_clash
);
    import xcvr_pkg::*;

    // lane 0: A to B, lane 1: B to A; bus 0 is A, bus 1 is B
    lane_ctl_t [NUM_DIR-1:0]         ctl;
    logic      [NUM_DIR-1:0][DW-1:0] bus_val;
    logic      [NUM_DIR-1:0][DW-1:0] ext_val;
    logic      [NUM_DIR-1:0]         ext_en;
    logic      [NUM_DIR-1:0][DW-1:0] lane_data;
    logic      [NUM_DIR-1:0]         lane_en;
    logic      [NUM_DIR-1:0]         clash;

    assign ctl[0]  = '{load: load_ab, pick_store: pick_ab_store, drive: drive_b_en};
    assign ctl[1]  = '{load: load_ba, pick_store: pick_ba_store, drive: drive_a_n};
    assign ext_val = {b_in, a_in};
    assign ext_en  = {b_in_en, a_in_en};

    generate
        for (genvar i = 0; i < NUM_DIR; i++) begin : g_dir
            // lane i reads bus i and drives bus (NUM_DIR-1-i)
            xcvr_lane #(.DW(DW), .OE_ACTIVE_LOW(i == 1)) u_lane (
                .clk      (clk),
                .rst      (rst),
                .ctl      (ctl[i]),
                .src_bus  (bus_val[i]),
                .drv_data (lane_data[i]),
                .drv_en   (lane_en[i])
            );
            xcvr_resolve #(.DW(DW)) u_bus (
                .clk      (clk),
                .rst      (rst),
                .ext_data (ext_val[i]),
                .ext_en   (ext_en[i]),
                .int_data (lane_data[NUM_DIR-1-i]),
                .int_en   (lane_en[NUM_DIR-1-i]),
                .bus      (bus_val[i]),
                .clash    (clash[i])
            );
        end
    endgenerate

    assign a_bus    = bus_val[0];
    assign b_bus    = bus_val[1];
    assign a_out    = lane_data[1];
    assign a_out_en = lane_en[1];
    assign b_out    = lane_data[0];
    assign b_out_en = lane_en[0];
    assign a_clash  = clash[0];
    assign b_clash  = clash[1];

    AST_ISOLATION: assert property (@(posedge clk) disable iff (rst)
        (!drive_b_en && drive_a_n) |=> (!a_out_en && !b_out_en)); // R5
    AST_LOAD_STAGGER: assert property (@(posedge clk) disable iff (rst)
        !($rose(load_ab) && $rose(load_ba) && (pick_ab_store || pick_ba_store))); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!a_out_en && !b_out_en && a_out == '0 && b_out == '0)); // R1
endmodule

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic       a_in_en = 0, b_in_en = 0, load_ab = 0, load_ba = 0;
    logic       pick_ab_store = 0, pick_ba_store = 0, drive_b_en = 0, drive_a_n = 1;
    logic [7:0] a_bus, b_bus, a_out, b_out;
    logic       a_out_en, b_out_en, a_clash, b_clash;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    logic [7:0] m_rab = 0, m_rba = 0, m_da = 0, m_db = 0, m_ka = 0, m_kb = 0;
    logic       m_ea = 0, m_eb = 0, m_pab = 0, m_pba = 0;

    always #2 clk = ~clk;

    dual_reg_xcvr dut (
        .clk(clk), .rst(rst), .a_in(a_in), .a_in_en(a_in_en), .b_in(b_in), .b_in_en(b_in_en),
        .load_ab(load_ab), .load_ba(load_ba), .pick_ab_store(pick_ab_store),
        .pick_ba_store(pick_ba_store), .drive_b_en(drive_b_en), .drive_a_n(drive_a_n),
        .a_bus(a_bus), .b_bus(b_bus), .a_out(a_out), .a_out_en(a_out_en),
        .b_out(b_out), .b_out_en(b_out_en), .a_clash(a_clash), .b_clash(b_clash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare against the model, then advance one clock
    task automatic step();
        logic [7:0] ra, rb;
        logic [7:0] n_rab, n_rba, n_da, n_db;
        #1;
        ra = a_in_en ? a_in : (m_ea ? m_da : m_ka);
        rb = b_in_en ? b_in : (m_eb ? m_db : m_kb);
        chk("R8 a_bus", a_bus, ra);
        chk("R8 b_bus", b_bus, rb);
        chk("R4 a_out", a_out, m_da);
        chk("R4 b_out", b_out, m_db);
        chk("R5 a_out_en", a_out_en, m_ea);
        chk("R5 b_out_en", b_out_en, m_eb);
        chk("R9 a_clash", a_clash, a_in_en & m_ea);
        chk("R9 b_clash", b_clash, b_in_en & m_eb);
        @(posedge clk);
        if (rst) begin
            m_rab = 0; m_rba = 0; m_da = 0; m_db = 0; m_ka = 0; m_kb = 0; m_ea = 0; m_eb = 0;
        end else begin
            n_rab = (load_ab && !m_pab) ? ra : m_rab;
            n_rba = (load_ba && !m_pba) ? rb : m_rba;
            n_db  = pick_ab_store ? m_rab : ra;
            n_da  = pick_ba_store ? m_rba : rb;
            m_rab = n_rab; m_rba = n_rba; m_da = n_da; m_db = n_db;
            m_eb = drive_b_en; m_ea = !drive_a_n; m_ka = ra; m_kb = rb;
        end
        m_pab = load_ab; m_pba = load_ba;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        step();
        chk("R1 no drive A", a_out_en, 0);
        chk("R1 no drive B", b_out_en, 0);
        chk("R1 keeper zero", a_bus, 8'h00);

        // R3: load with select high and drivers off
        a_in_en = 1; a_in = 8'h3C; load_ab = 1; pick_ab_store = 1; drive_b_en = 0;
        step();
        load_ab = 0; drive_b_en = 1;
        step();
        chk("R3 stored value on B", b_out, 8'h3C);
        chk("R5 B driven", b_out_en, 1);
        chk("R4 b_bus from store", b_bus, 8'h3C);

        // R2: strobe held high loads once
        load_ab = 1; step();
        a_in = 8'h99; step(); step();
        chk("R2 held strobe no reload", b_out, 8'h3C);

        // R4 / R11: select switching
        pick_ab_store = 0; step();
        chk("R4 live A on B", b_out, 8'h99);
        pick_ab_store = 1; step();
        chk("R11 direct return to store", b_out, 8'h3C);

        // R6: copy A into both registers through live B
        load_ab = 0; a_in = 8'hA5; pick_ab_store = 0; pick_ba_store = 0;
        step(); step();
        load_ab = 1; load_ba = 1; step();
        load_ab = 0; load_ba = 0; pick_ab_store = 1; pick_ba_store = 1; drive_a_n = 0; a_in_en = 0;
        step();
        chk("R6 B-to-A reg holds A data", a_out, 8'hA5);
        chk("R6 A bus shows copy", a_bus, 8'hA5);
        chk("R6 A-to-B reg", b_out, 8'hA5);

        // R8 / R9: contention on A
        a_in_en = 1; a_in = 8'h0F; #1;
        chk("R9 clash A", a_clash, 1);
        chk("R8 external wins", a_bus, 8'h0F);
        step();

        // R7: bus hold with both live paths
        pick_ab_store = 0; pick_ba_store = 0; a_in = 8'h5A;
        repeat (3) step();
        a_in_en = 0;
        repeat (4) step();
        chk("R7 A holds", a_bus, 8'h5A);
        chk("R7 B holds", b_bus, 8'h5A);

        // R5 isolation and keeper
        drive_b_en = 0; drive_a_n = 1; step();
        chk("R5 isolation A", a_out_en, 0);
        chk("R5 isolation B", b_out_en, 0);
        chk("R8 keeper A", a_bus, 8'h5A);

        // R10: simultaneous loads, selects low
        a_in_en = 1; a_in = 8'h11; b_in_en = 1; b_in = 8'h22; load_ab = 1; load_ba = 1;
        step();
        load_ab = 0; load_ba = 0; a_in_en = 0; b_in_en = 0;
        pick_ab_store = 1; pick_ba_store = 1; drive_b_en = 1; drive_a_n = 0;
        step();
        chk("R10 A-to-B captured", b_bus, 8'h11);
        chk("R10 B-to-A captured", a_bus, 8'h22);
        pick_ab_store = 0; pick_ba_store = 0;

        // random phase under the load-ordering rule
        for (int i = 0; i < 400; i++) begin
            logic nab, nba;
            a_in = 8'($urandom); b_in = 8'($urandom);
            a_in_en = ($urandom % 3) == 0; b_in_en = ($urandom % 3) == 0;
            pick_ab_store = $urandom % 2; pick_ba_store = $urandom % 2;
            drive_b_en = $urandom % 2; drive_a_n = $urandom % 2;
            nab = $urandom % 2; nba = $urandom % 2;
            if (nab && !load_ab && nba && !load_ba && (pick_ab_store || pick_ba_store))
                nba = 0;
            load_ab = nab; load_ba = nba;
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule